// File: doc/BRIEF.md
# Transfer Descriptor Retry and Status Update

This block holds the control state of one USB host transfer descriptor and works out its write-back after every bus transaction. Software loads a descriptor, which sets the 2-bit retry counter, the PID code and the active bit, and clears the halted bit and all error status. Each transaction result then arrives as a one-cycle pulse carrying a one-hot result code. The block updates the counter, the active and halted bits and the sticky error status bits. It presents the new values with a write-back strobe one cycle later.

The result input is always ready. It has no back-pressure, so a pulse is either applied or flagged as a protocol error in the cycle it is sampled. The write-back strobe is not stalled. Alongside the strobe the block raises an error-interrupt request, gated by an enable input, when the retry budget runs out. It also drives, at all times, the token byte that matches the stored PID code.

Top module: `qtd_retry_update`

## Requirements
- R1: After reset the counter, PID, active, halted and status outputs are all zero, and the strobe, interrupt and protocol-error outputs are low.
- R2: A load pulse stores the given counter, PID and active bit and clears halted and all four status bits (bit0 transaction error, bit1 data buffer error, bit2 babble, bit3 stall). The new values show one cycle later, with no write-back strobe.
- R3: The token byte follows the stored PID code: 00 gives 0xE1 (OUT), 01 gives 0x69 (IN), 10 gives 0x2D (SETUP) and 11 (reserved) gives 0x00.
- R4: The result code is one-hot: bit0 success, bit1 transaction error, bit2 data buffer error, bit3 babble, bit4 stall. A transaction error with a counter of 2 or 3 lowers the counter by one, keeps the descriptor active and sets status bit0.
- R5: A transaction error with a counter of 1 sets the counter to 0, clears active, sets halted and sets status bit0.
- R6: The error interrupt pulses with the write-back strobe only when the counter has just stepped from 1 to 0 and the interrupt enable input was high at the result pulse.
- R7: With a counter of 0, a transaction error leaves the counter at 0 and the descriptor active (unlimited retries), and still sets status bit0.
- R8: A data buffer error sets status bit1 and changes neither the counter nor the active bit.
- R9: Babble or stall clears active, sets halted and sets status bit2 or bit3 respectively, with the counter unchanged.
- R10: On success with a non-zero counter, the counter is reloaded to 3 when the endpoint is high speed, or when the asynchronous-schedule flag is set and the PID is OUT or IN. Otherwise it is unchanged.
- R11: On success with a counter of 0, the counter stays 0.
- R12: A result with a reserved PID, on an inactive descriptor, or with a code that is not one-hot changes no state, gives no strobe and pulses the protocol-error output for one cycle.
- R13: An accepted result gives exactly one write-back strobe on the next cycle. A load in the same cycle as a result takes priority, and the result is dropped with no strobe and no protocol error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Software load of a new descriptor |
| load_cerr | input | 2 | Retry counter value to load |
| load_pid | input | 2 | PID code to load |
| load_active | input | 1 | Active bit to load |
| ep_high_speed | input | 1 | Endpoint is high speed |
| async_sched | input | 1 | Descriptor is on the asynchronous schedule |
| err_irq_en | input | 1 | Error interrupt enable |
| res_valid | input | 1 | One-cycle transaction result pulse |
| res_code | input | 5 | One-hot result code |
| wb_valid | output | 1 | Write-back strobe |
| wb_cerr | output | 2 | Current retry counter |
| wb_pid | output | 2 | Current PID code |
| wb_active | output | 1 | Current active bit |
| wb_halted | output | 1 | Current halted bit |
| wb_status | output | 4 | Sticky error status bits |
| err_irq | output | 1 | Error interrupt request pulse |
| proto_err | output | 1 | Protocol error pulse |
| token_byte | output | 8 | Token byte for the stored PID |

## Verification
Every result pulse and every load is sampled on one clock edge. The write-back fields, the strobe, the interrupt and the protocol-error flag all come from registers loaded on that edge, so they are due exactly one cycle after the stimulus. The token byte is a decode of the stored PID, so it is also due one cycle after a load. The driver applies inputs on the falling edge and queues the expected state for the next rising edge. The monitor compares the outputs a quarter period after that rising edge and removes one queued item per cycle. Each outcome is therefore checked in the one cycle it is due and cannot be confused with the next stimulus.

// File: rtl/qtd_retry_pkg.sv
package qtd_retry_pkg;
  localparam int CERR_W  = 2;
  localparam int PID_W   = 2;
  localparam int RES_W   = 5;
  localparam int STAT_W  = 4;
  localparam int TOKEN_W = 8;

  // result code bit positions
  localparam int RB_OK     = 0;
  localparam int RB_XACT   = 1;
  localparam int RB_DBUF   = 2;
  localparam int RB_BABBLE = 3;
  localparam int RB_STALL  = 4;

  // status bit positions
  localparam int SB_XACT   = 0;
  localparam int SB_DBUF   = 1;
  localparam int SB_BABBLE = 2;
  localparam int SB_STALL  = 3;

  typedef enum logic [PID_W-1:0] {
    PID_OUT   = 2'b00,
    PID_IN    = 2'b01,
    PID_SETUP = 2'b10,
    PID_RSV   = 2'b11
  } pid_e;

  typedef enum logic [2:0] {
    OC_NONE, OC_OK, OC_XACT, OC_DBUF, OC_BABBLE, OC_STALL
  } outcome_e;
endpackage

// File: rtl/qtd_outcome_decode.sv
module qtd_outcome_decode
  import qtd_retry_pkg::*;
#(
  parameter int N_RES = RES_W
) (
  input  logic             valid,
  input  logic [N_RES-1:0] code,
  output outcome_e         kind,
  output logic             bad_code
);
  localparam int CNT_W = $clog2(N_RES + 1);
  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < N_RES; i++) ones = ones + CNT_W'(code[i]);
  end

  assign bad_code = valid && (ones != CNT_W'(1));

  always_comb begin
    kind = OC_NONE;
    if (valid && !bad_code) begin
      unique case (1'b1)
        code[RB_OK]:     kind = OC_OK;
        code[RB_XACT]:   kind = OC_XACT;
        code[RB_DBUF]:   kind = OC_DBUF;
        code[RB_BABBLE]: kind = OC_BABBLE;
        code[RB_STALL]:  kind = OC_STALL;
        default:         kind = OC_NONE;
      endcase
    end
  end
endmodule

// File: rtl/qtd_cerr_step.sv
module qtd_cerr_step
  import qtd_retry_pkg::*;
#(
  parameter int CW = CERR_W,
  parameter int SW = STAT_W
) (
  input  logic [CW-1:0]    cerr,
  input  logic [PID_W-1:0] pid,
  input  logic             high_speed,
  input  logic             async_q,
  input  outcome_e         kind,
  output logic [CW-1:0]    cerr_nxt,
  output logic             halt,
  output logic             budget_out,
  output logic [SW-1:0]    stat_set
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] CONE = CW'(1);

  logic counting, reload_ok;
  assign counting  = (cerr != '0);
  assign reload_ok = high_speed ||
                     (async_q && (pid == PID_OUT || pid == PID_IN));

  always_comb begin
    cerr_nxt   = cerr;
    halt       = 1'b0;
    budget_out = 1'b0;
    stat_set   = '0;
    case (kind)
      OC_OK: if (counting && reload_ok) cerr_nxt = CMAX;
      OC_XACT: begin
        stat_set[SB_XACT] = 1'b1;
        if (cerr == CONE) begin
          cerr_nxt   = '0;
          halt       = 1'b1;
          budget_out = 1'b1;
        end else if (counting) begin
          cerr_nxt = cerr - CONE;
        end
      end
      OC_DBUF:   stat_set[SB_DBUF] = 1'b1;
      OC_BABBLE: begin stat_set[SB_BABBLE] = 1'b1; halt = 1'b1; end
      OC_STALL:  begin stat_set[SB_STALL]  = 1'b1; halt = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/qtd_token_enc.sv
module qtd_token_enc
  import qtd_retry_pkg::*;
(
  input  logic [PID_W-1:0]   pid,
  output logic [TOKEN_W-1:0] token
);
  always_comb begin
    case (pid)
      PID_OUT:   token = 8'hE1;
      PID_IN:    token = 8'h69;
      PID_SETUP: token = 8'h2D;
      default:   token = 8'h00;
    endcase
  end
endmodule

// File: rtl/qtd_retry_update.sv
module qtd_retry_update
  import qtd_retry_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [CERR_W-1:0]  load_cerr,
  input  logic [PID_W-1:0]   load_pid,
  input  logic               load_active,
  input  logic               ep_high_speed,
  input  logic               async_sched,
  input  logic               err_irq_en,
  input  logic               res_valid,
  input  logic [RES_W-1:0]   res_code,
  output logic               wb_valid,
  output logic [CERR_W-1:0]  wb_cerr,
  output logic [PID_W-1:0]   wb_pid,
  output logic               wb_active,
  output logic               wb_halted,
  output logic [STAT_W-1:0]  wb_status,
  output logic               err_irq,
  output logic               proto_err,
  output logic [TOKEN_W-1:0] token_byte
);
  logic [CERR_W-1:0] cerr_q, cerr_nxt;
  logic [PID_W-1:0]  pid_q;
  logic              active_q, halted_q;
  logic [STAT_W-1:0] status_q, stat_set;
  logic              strobe_q, irq_q, proto_q;
  logic              accept, bad, upd, halt, budget_out, bad_code;
  outcome_e          kind;

  qtd_outcome_decode #(.N_RES(RES_W)) u_dec (
    .valid(res_valid), .code(res_code), .kind(kind), .bad_code(bad_code)
  );

  qtd_cerr_step #(.CW(CERR_W), .SW(STAT_W)) u_step (
    .cerr(cerr_q), .pid(pid_q), .high_speed(ep_high_speed),
    .async_q(async_sched), .kind(kind), .cerr_nxt(cerr_nxt),
    .halt(halt), .budget_out(budget_out), .stat_set(stat_set)
  );

  qtd_token_enc u_tok (.pid(pid_q), .token(token_byte));

  assign accept = res_valid && !load_en;
  assign bad    = accept && (bad_code || !active_q || pid_q == PID_RSV);
  assign upd    = accept && !bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cerr_q   <= '0;
      pid_q    <= '0;
      active_q <= 1'b0;
      halted_q <= 1'b0;
      strobe_q <= 1'b0;
      irq_q    <= 1'b0;
      proto_q  <= 1'b0;
    end else begin
      strobe_q <= upd;
      irq_q    <= upd && budget_out && err_irq_en;
      proto_q  <= bad;
      if (load_en) begin
        cerr_q   <= load_cerr;
        pid_q    <= load_pid;
        active_q <= load_active;
        halted_q <= 1'b0;
      end else if (upd) begin
        cerr_q <= cerr_nxt;
        if (halt) begin
          active_q <= 1'b0;
          halted_q <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < STAT_W; g++) begin : g_stat
    always_ff @(posedge clk) begin
      if (!rst_n)                  status_q[g] <= 1'b0;
      else if (load_en)            status_q[g] <= 1'b0;
      else if (upd && stat_set[g]) status_q[g] <= 1'b1;
    end
  end

  assign wb_valid  = strobe_q;
  assign wb_cerr   = cerr_q;
  assign wb_pid    = pid_q;
  assign wb_active = active_q;
  assign wb_halted = halted_q;
  assign wb_status = status_q;
  assign err_irq   = irq_q;
  assign proto_err = proto_q;
endmodule

// File: rtl/qtd_retry_checks.sv
module qtd_retry_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       load_en,
  input logic       err_irq_en,
  input logic       ep_high_speed,
  input logic       res_valid,
  input logic [4:0] res_code,
  input logic       wb_valid,
  input logic [1:0] wb_cerr,
  input logic [1:0] wb_pid,
  input logic       wb_active,
  input logic       wb_halted,
  input logic [3:0] wb_status,
  input logic       err_irq,
  input logic       proto_err
);
  a_r13_strobe_after_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !load_en && wb_active && wb_pid != 2'b11 && $onehot0(res_code) &&
    res_code != 5'b0 |=> wb_valid);

  a_r13_load_drops_result: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !wb_valid && !proto_err);

  a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> $past(err_irq_en) && wb_valid && wb_cerr == 2'b00 && wb_halted);

  a_r5_final_step_halts: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && $past(wb_cerr) == 2'b01 && wb_cerr == 2'b00 |-> wb_halted && !wb_active);

  a_r11_zero_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && $past(wb_cerr) == 2'b00 |-> wb_cerr == 2'b00);

  a_r8_dbuf_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && $past(res_code) == 5'b00100 |-> wb_cerr == $past(wb_cerr) && wb_active);

  a_r9_babble_stall_halt: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && ($past(res_code) == 5'b01000 || $past(res_code) == 5'b10000)
    |-> wb_halted && !wb_active && wb_cerr == $past(wb_cerr));

  a_r10_hs_reload: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && $past(res_code) == 5'b00001 && $past(wb_cerr) != 2'b00 &&
    $past(ep_high_speed) |-> wb_cerr == 2'b11);

  a_r12_proto_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !wb_valid && $stable(wb_cerr) && $stable(wb_status) &&
    $stable(wb_active) && $stable(wb_halted));

  a_r9_halted_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    wb_halted |-> !wb_active);
endmodule

bind qtd_retry_update qtd_retry_checks u_chk (.*);

// File: tb/test_qtd_retry_update.sv
module test_qtd_retry_update;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_en = 0, load_active = 0, ep_high_speed = 0, async_sched = 0;
  logic err_irq_en = 0, res_valid = 0;
  logic [1:0] load_cerr = 0, load_pid = 0;
  logic [4:0] res_code = 0;
  logic wb_valid, wb_active, wb_halted, err_irq, proto_err;
  logic [1:0] wb_cerr, wb_pid;
  logic [3:0] wb_status;
  logic [7:0] token_byte;

  always #10 clk = ~clk;

  qtd_retry_update i_qtd_retry_update (.*);

  typedef struct {
    logic wbv, irq, proto, act, hlt;
    logic [1:0] cerr;
    logic [3:0] stat;
    logic [7:0] tok;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model of the descriptor state
  logic [1:0] m_cerr = 0, m_pid = 0;
  logic m_act = 0, m_hlt = 0;
  logic [3:0] m_stat = 0;

  function automatic logic [7:0] tok_of(logic [1:0] p);
    return p == 2'b00 ? 8'hE1 : p == 2'b01 ? 8'h69 : p == 2'b10 ? 8'h2D : 8'h00;
  endfunction

  function automatic exp_t snap(logic wbv, logic irq, logic proto, string tag);
    exp_t e;
    e.wbv = wbv; e.irq = irq; e.proto = proto; e.act = m_act; e.hlt = m_hlt;
    e.cerr = m_cerr; e.stat = m_stat; e.tok = tok_of(m_pid); e.tag = tag;
    return e;
  endfunction

  task automatic do_load(logic [1:0] c, logic [1:0] p, logic a, string tag);
    @(negedge clk);
    load_en = 1; load_cerr = c; load_pid = p; load_active = a;
    m_cerr = c; m_pid = p; m_act = a; m_hlt = 0; m_stat = 0;
    q.push_back(snap(0, 0, 0, tag));
    @(negedge clk);
    load_en = 0;
  endtask

  task automatic do_res(logic [4:0] code, logic hs, logic as, logic en, string tag);
    logic irq = 0, proto = 0;
    @(negedge clk);
    res_valid = 1; res_code = code; ep_high_speed = hs; async_sched = as; err_irq_en = en;
    if ($countones(code) != 1 || !m_act || m_pid == 2'b11) proto = 1;
    else if (code[0]) begin
      if (m_cerr != 0 && (hs || (as && m_pid != 2'b10))) m_cerr = 2'b11;
    end else if (code[1]) begin
      m_stat[0] = 1;
      if (m_cerr == 1) begin m_cerr = 0; m_act = 0; m_hlt = 1; irq = en; end
      else if (m_cerr != 0) m_cerr = m_cerr - 1;
    end else if (code[2]) m_stat[1] = 1;
    else begin
      if (code[3]) m_stat[2] = 1; else m_stat[3] = 1;
      m_act = 0; m_hlt = 1;
    end
    q.push_back(snap(!proto, irq, proto, tag));
    @(negedge clk);
    res_valid = 0; res_code = 0;
  endtask

  task automatic compare(exp_t e);
    n_run++;
    if (wb_valid !== e.wbv || err_irq !== e.irq || proto_err !== e.proto ||
        wb_active !== e.act || wb_halted !== e.hlt || wb_cerr !== e.cerr ||
        wb_status !== e.stat || token_byte !== e.tok) begin
      n_fail++;
      $display("FAIL %s: got v%b i%b p%b a%b h%b c%0d s%b t%h exp v%b i%b p%b a%b h%b c%0d s%b t%h",
        e.tag, wb_valid, err_irq, proto_err, wb_active, wb_halted, wb_cerr, wb_status,
        token_byte, e.wbv, e.irq, e.proto, e.act, e.hlt, e.cerr, e.stat, e.tok);
    end
  endtask

  // monitor: sample a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk); #5;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #5;
    compare(snap(0, 0, 0, "R1 reset state"));
    do_load(2'b11, 2'b00, 1, "R2 R3 load OUT");
    do_res(5'b00010, 0, 0, 1, "R4 xact 3->2");
    do_res(5'b00010, 0, 0, 1, "R4 xact 2->1");
    do_res(5'b00010, 0, 0, 1, "R5 R6 xact 1->0 irq");
    do_res(5'b00001, 1, 0, 1, "R12 result on inactive");
    do_load(2'b01, 2'b01, 1, "R2 R3 load IN");
    do_res(5'b00010, 0, 0, 0, "R6 budget out no irq");
    do_load(2'b00, 2'b01, 1, "R2 load zero counter");
    do_res(5'b00010, 0, 0, 1, "R7 unlimited 1");
    do_res(5'b00010, 0, 1, 1, "R7 unlimited 2");
    do_res(5'b00001, 1, 1, 1, "R11 no reload from 0");
    do_load(2'b10, 2'b01, 1, "R2 load IN cerr2");
    do_res(5'b00100, 0, 0, 1, "R8 data buffer");
    do_res(5'b00001, 0, 0, 1, "R10 no reload full speed periodic");
    do_res(5'b00001, 0, 1, 1, "R10 reload async IN");
    do_load(2'b10, 2'b10, 1, "R3 load SETUP");
    do_res(5'b00010, 0, 0, 1, "R4 SETUP xact 2->1");
    do_res(5'b00001, 0, 1, 1, "R10 no reload async SETUP");
    do_res(5'b00001, 1, 0, 1, "R10 reload high speed SETUP");
    do_load(2'b11, 2'b00, 1, "R2 reload descriptor");
    do_res(5'b01000, 0, 0, 1, "R9 babble halts");
    do_load(2'b10, 2'b00, 1, "R2 clears status");
    do_res(5'b10000, 1, 0, 1, "R9 stall halts");
    do_load(2'b11, 2'b11, 1, "R3 reserved token");
    do_res(5'b00001, 1, 0, 1, "R12 reserved pid");
    do_load(2'b11, 2'b01, 1, "R2 load for code check");
    do_res(5'b00011, 1, 0, 1, "R12 not one-hot");
    do_res(5'b00000, 1, 0, 1, "R12 empty code");
    // R13: load and result in the same cycle, load wins
    @(negedge clk);
    load_en = 1; load_cerr = 2'b10; load_pid = 2'b00; load_active = 1;
    res_valid = 1; res_code = 5'b10000;
    m_cerr = 2'b10; m_pid = 2'b00; m_act = 1; m_hlt = 0; m_stat = 0;
    q.push_back(snap(0, 0, 0, "R13 load beats result"));
    @(negedge clk);
    load_en = 0; res_valid = 0; res_code = 0;
    do_res(5'b00100, 0, 0, 1, "R13 strobe after accepted result");
    repeat (4) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule